// File: doc/BRIEF.md
# Display RAM Fill Sequencer

This block takes display bytes from a command front end and scatters their bits into a 24-word by 4-bit segment memory. Each word address stands for one segment output, and each bit index within a word stands for one backplane phase. A stored 1 lights the segment. How many bits of a byte land in each word depends on the multiplex drive mode, so one byte covers between two and eight word addresses. The block writes one word address per cycle through a masked write port. It holds `in_ready` low while it writes out a byte.

A 5-bit pointer selects the word to write. A 3-bit device counter is compared with the strapped subaddress pins. Only a device whose counter matches its pins writes; every device advances its pointer either way. When the pointer runs past the last word, it wraps to 0 and the device counter increments. This can happen in the middle of a byte, so a stream of bytes spills over into the next cascaded device. The command decoder loads the pointer and the counter directly. In static and 1:2 modes, a bank input moves the writes into the upper half of each word.

Top module: `lcdr_ram_loader`

## Requirements
- R1: After reset the pointer and the device counter are 0, `in_ready` is 1 and `wr_en` is 0.
- R2: Static mode (`drive_mode`=2'b00): a byte is written one bit per word into bit 0 of 8 consecutive words. The MSB goes to the lowest word. The pointer advances by 8.
- R3: 1:2 mode (2'b01): each of 4 consecutive words receives 2 bits into bits 0..1. The earlier byte bit goes to the lower bit index. The pointer advances by 4.
- R4: 1:3 mode (2'b10): the first two of 3 consecutive words receive 3 bits into bits 0..2. The third word receives the last 2 bits into bits 0..1, and its bit 2 is left unchanged. The pointer advances by 3.
- R5: 1:4 mode (2'b11): bits 7..4 fill bits 0..3 of the first word and bits 3..0 fill bits 0..3 of the next word. The pointer advances by 2.
- R6: With `in_bank`=1, static mode writes bit 2 instead of bit 0, and 1:2 mode writes bits 2..3 instead of bits 0..1. In 1:3 and 1:4 modes `in_bank` has no effect.
- R7: A word is written only while the device counter equals `hw_subaddr`. On a mismatch nothing is written, but the pointer advances exactly as it would on a write.
- R8: A step from word 23 (or above) sets the pointer to 0 and increments the device counter modulo 8. The match is checked again for every word, including the words of a byte that crosses the wrap.
- R9: A byte is accepted on a cycle with `in_valid` and `in_ready` both high. `in_ready` then stays low for exactly one cycle per word the byte covers (8, 4, 3 or 2). A byte held valid while `in_ready` is low is not taken until `in_ready` returns.
- R10: The drive mode and the bank are captured when a byte is accepted. Changes to them while that byte is being written have no effect on it.
- R11: `selected` is 1 exactly when the device counter equals `hw_subaddr`.
- R12: `ptr_load` and `sub_load` take effect at the next clock edge and override a coinciding step advance. A pointer load value above 23 is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Display byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Display byte, consumed MSB first |
| drive_mode | input | 2 | 00 static, 01 1:2, 10 1:3, 11 1:4 |
| in_bank | input | 1 | Alternate-bank write select |
| ptr_load | input | 1 | Load the word pointer |
| ptr_value | input | 5 | Pointer load value |
| sub_load | input | 1 | Load the device counter |
| sub_value | input | 3 | Device counter load value |
| hw_subaddr | input | 3 | Strapped device subaddress |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 5 | Word address of the write |
| wr_mask | output | 4 | Bits of the word to write |
| wr_data | output | 4 | Bit values to write |
| selected | output | 1 | Device counter matches the strapped subaddress |

## Verification
The assertions check the following on every cycle:
- Writes occur only while busy and only while selected.
- Write addresses stay within the memory.
- The pointer steps by one, with wrap, on each busy cycle that has no load.
- The device counter changes only on a load or on a wrap to word 0.
- In static mode every write mask has one bit set.
- In 1:3 mode bit 3 is never written.
- Accepting a byte drops `in_ready`.

Only the bench scenarios can show where each byte bit ends up and which bits stay unchanged. It sweeps every start word for every mode, both banks, and a counter that starts one below or equal to the strapped value, and compares the whole memory against an arithmetic model after each scenario. The same holds for capture of the mode at acceptance, for a byte held valid during back-pressure, and for clamping of the load value.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
  typedef enum logic [1:0] {
    DRV_STATIC = 2'b00,
    DRV_MUX2   = 2'b01,
    DRV_MUX3   = 2'b10,
    DRV_MUX4   = 2'b11
  } drive_e;

  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned CELL_BITS = 4;
endpackage

// File: rtl/lcdr_ptr_track.sv
module lcdr_ptr_track #(
  parameter int unsigned NUM_ADDR = 24,
  parameter int unsigned SUB_W    = 3,
  localparam int unsigned PTR_W   = $clog2(NUM_ADDR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_load,
  input  logic [PTR_W-1:0] ptr_value,
  input  logic             sub_load,
  input  logic [SUB_W-1:0] sub_value,
  input  logic             step,
  input  logic [SUB_W-1:0] hw_subaddr,
  output logic [PTR_W-1:0] ptr,
  output logic [SUB_W-1:0] sub,
  output logic             match
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_ADDR - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [SUB_W-1:0] sub_q;
  logic             at_end;
  logic             wrap_evt;
  logic [PTR_W-1:0] load_clamped;

  // Overflow is judged on the current pointer; a load in the same cycle
  // replaces the advance and suppresses the counter bump.
  assign at_end       = (ptr_q >= LAST);
  assign wrap_evt     = step && !ptr_load && at_end;
  assign load_clamped = (ptr_value > LAST) ? '0 : ptr_value;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_load) begin
      ptr_q <= load_clamped;
    end else if (step) begin
      ptr_q <= at_end ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (sub_load) begin
      sub_q <= sub_value;
    end else if (wrap_evt) begin
      sub_q <= sub_q + 1'b1;
    end
  end

  assign ptr   = ptr_q;
  assign sub   = sub_q;
  assign match = (sub_q == hw_subaddr);
endmodule

// File: rtl/lcdr_bit_feed.sv
module lcdr_bit_feed
  import lcdr_pkg::*;
#(
  parameter int unsigned BYTE_W = BYTE_BITS,
  parameter int unsigned CELL_W = CELL_BITS,
  localparam int unsigned CNT_W    = $clog2(BYTE_W + 1),
  localparam int unsigned BANK_OFS = CELL_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  input  drive_e            mode_in,
  input  logic              bank_in,
  output logic              busy,
  output drive_e            mode_cur,
  output logic [CELL_W-1:0] cell_mask,
  output logic [CELL_W-1:0] cell_data
);
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              busy_q;
  drive_e            mode_q;
  logic              bank_q;

  logic [CNT_W-1:0]  per_word;
  logic [CNT_W-1:0]  used;
  logic              last_word;
  logic              alt_bank;
  logic [CELL_W-1:0] raw_mask;
  logic [CELL_W-1:0] raw_data;

  // Bits per word equals the number of backplanes; the tail word of a
  // byte may take fewer (1:3 leaves two bits for the last word).
  assign per_word  = CNT_W'(mode_q) + CNT_W'(1);
  assign used      = (left_q < per_word) ? left_q : per_word;
  assign last_word = (left_q <= per_word);
  assign alt_bank  = bank_q && (mode_q == DRV_STATIC || mode_q == DRV_MUX2);

  for (genvar j = 0; j < CELL_W; j++) begin : g_lane
    assign raw_mask[j] = (CNT_W'(j) < used);
    assign raw_data[j] = raw_mask[j] & sh_q[BYTE_W-1-j];
  end

  assign cell_mask = alt_bank ? (raw_mask << BANK_OFS) : raw_mask;
  assign cell_data = alt_bank ? (raw_data << BANK_OFS) : raw_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      mode_q <= DRV_MUX4;
      bank_q <= 1'b0;
    end else if (take) begin
      sh_q   <= byte_in;
      left_q <= CNT_W'(BYTE_W);
      busy_q <= 1'b1;
      mode_q <= mode_in;
      bank_q <= bank_in;
    end else if (busy_q) begin
      sh_q   <= sh_q << used;
      left_q <= left_q - used;
      if (last_word) busy_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign mode_cur = mode_q;
endmodule

// File: rtl/lcdr_ram_loader.sv
module lcdr_ram_loader
  import lcdr_pkg::*;
#(
  parameter int unsigned NUM_ADDR = 24,
  parameter int unsigned SUB_W    = 3,
  localparam int unsigned PTR_W   = $clog2(NUM_ADDR)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BYTE_BITS-1:0] in_byte,
  input  logic [1:0]           drive_mode,
  input  logic                 in_bank,
  input  logic                 ptr_load,
  input  logic [PTR_W-1:0]     ptr_value,
  input  logic                 sub_load,
  input  logic [SUB_W-1:0]     sub_value,
  input  logic [SUB_W-1:0]     hw_subaddr,
  output logic                 wr_en,
  output logic [PTR_W-1:0]     wr_addr,
  output logic [CELL_BITS-1:0] wr_mask,
  output logic [CELL_BITS-1:0] wr_data,
  output logic                 selected
);
  logic             busy;
  logic             take;
  logic             match;
  drive_e           mode_q;
  logic [PTR_W-1:0] ptr_q;
  logic [SUB_W-1:0] sub_q;

  assign in_ready = !busy;
  assign take     = in_valid && !busy;

  lcdr_bit_feed #(
    .BYTE_W (BYTE_BITS),
    .CELL_W (CELL_BITS)
  ) u_feed (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .byte_in   (in_byte),
    .mode_in   (drive_e'(drive_mode)),
    .bank_in   (in_bank),
    .busy      (busy),
    .mode_cur  (mode_q),
    .cell_mask (wr_mask),
    .cell_data (wr_data)
  );

  lcdr_ptr_track #(
    .NUM_ADDR (NUM_ADDR),
    .SUB_W    (SUB_W)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_load   (ptr_load),
    .ptr_value  (ptr_value),
    .sub_load   (sub_load),
    .sub_value  (sub_value),
    .step       (busy),
    .hw_subaddr (hw_subaddr),
    .ptr        (ptr_q),
    .sub        (sub_q),
    .match      (match)
  );

  assign wr_en    = busy && match;
  assign wr_addr  = ptr_q;
  assign selected = match;
endmodule

// File: rtl/lcdr_ram_loader_chk.sv
module lcdr_ram_loader_chk
  import lcdr_pkg::*;
#(
  parameter int unsigned NUM_ADDR = 24,
  parameter int unsigned SUB_W    = 3,
  localparam int unsigned PTR_W   = $clog2(NUM_ADDR)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 ptr_load,
  input logic                 sub_load,
  input logic                 wr_en,
  input logic [PTR_W-1:0]     wr_addr,
  input logic [CELL_BITS-1:0] wr_mask,
  input logic                 selected,
  input drive_e               mode_q,
  input logic [PTR_W-1:0]     ptr_q,
  input logic [SUB_W-1:0]     sub_q
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_ADDR - 1);

  a_r9_take_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  a_r9_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !in_ready);

  a_r7_write_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> selected);

  a_r8_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= LAST));

  a_r8_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && $past(!in_ready) && !$past(ptr_load) |->
      ptr_q == (($past(ptr_q) >= LAST) ? '0 : $past(ptr_q) + 1'b1));

  a_r8_sub_moves_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sub_load) && (sub_q != $past(sub_q)) |-> (ptr_q == '0));

  a_r2_static_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && mode_q == DRV_STATIC |-> $countones(wr_mask) == 1);

  a_r4_mux3_no_bit3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && mode_q == DRV_MUX3 |-> !wr_mask[3] && wr_mask[0]);
endmodule

bind lcdr_ram_loader lcdr_ram_loader_chk #(
  .NUM_ADDR (NUM_ADDR),
  .SUB_W    (SUB_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .ptr_load (ptr_load),
  .sub_load (sub_load),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_mask  (wr_mask),
  .selected (selected),
  .mode_q   (mode_q),
  .ptr_q    (ptr_q),
  .sub_q    (sub_q)
);

// File: tb/lcdr_ram_loader_bench.sv
module lcdr_ram_loader_bench;
  localparam int NA = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = '0;
  logic [1:0] drive_mode = '0;
  logic       in_bank = 1'b0;
  logic       ptr_load = 1'b0;
  logic [4:0] ptr_value = '0;
  logic       sub_load = 1'b0;
  logic [2:0] sub_value = '0;
  logic [2:0] hw_subaddr = '0;
  logic       wr_en;
  logic [4:0] wr_addr;
  logic [3:0] wr_mask;
  logic [3:0] wr_data;
  logic       selected;

  always #2 clk = ~clk;

  lcdr_ram_loader u_lcdr_ram_loader (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .drive_mode(drive_mode), .in_bank(in_bank),
    .ptr_load(ptr_load), .ptr_value(ptr_value), .sub_load(sub_load),
    .sub_value(sub_value), .hw_subaddr(hw_subaddr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(wr_data),
    .selected(selected)
  );

  int errors = 0;
  int checks = 0;
  int wr_count = 0;
  logic       seed_req = 1'b0;
  logic [3:0] seed_val = '0;
  logic [3:0] dut_ram [NA];
  logic [3:0] exp_ram [NA];
  int mp, ms;

  // Memory built from the write port
  always @(posedge clk) begin
    if (seed_req) begin
      for (int a = 0; a < NA; a++) dut_ram[a] <= 4'(a * 7) ^ seed_val;
    end else if (wr_en) begin
      for (int j = 0; j < 4; j++) if (wr_mask[j]) dut_ram[wr_addr][j] <= wr_data[j];
      wr_count <= wr_count + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic seed(input logic [3:0] s);
    @(negedge clk);
    seed_val = s;
    seed_req = 1'b1;
    for (int a = 0; a < NA; a++) exp_ram[a] = 4'(a * 7) ^ s;
    @(negedge clk);
    seed_req = 1'b0;
  endtask

  task automatic load(input int p, input int s);
    @(negedge clk);
    ptr_load = 1'b1; ptr_value = 5'(p);
    sub_load = 1'b1; sub_value = 3'(s);
    @(negedge clk);
    ptr_load = 1'b0; sub_load = 1'b0;
    mp = (p > NA - 1) ? 0 : p;
    ms = s & 7;
  endtask

  // Bit-serial reference: MSB first, lower cell bit first, advance per word
  task automatic model_byte(input logic [7:0] b, input int mode, input bit bank);
    int n, base, k;
    n = mode + 1;
    base = (bank && mode <= 1) ? 2 : 0;
    k = 0;
    for (int i = 7; i >= 0; i--) begin
      if (ms == int'(hw_subaddr)) exp_ram[mp][base + k] = b[i];
      k++;
      if (k == n || i == 0) begin
        k = 0;
        if (mp >= NA - 1) begin mp = 0; ms = (ms + 1) & 7; end
        else mp++;
      end
    end
  endtask

  function automatic int words_per_byte(input int mode);
    return (mode == 0) ? 8 : (mode == 1) ? 4 : (mode == 2) ? 3 : 2;
  endfunction

  task automatic send_byte(input logic [7:0] b, input int mode, input bit bank,
                           input int alt_mode, input string req);
    int busy_cyc;
    @(negedge clk);
    in_byte = b; drive_mode = 2'(mode); in_bank = bank; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (alt_mode >= 0) begin drive_mode = 2'(alt_mode); in_bank = ~bank; end
    busy_cyc = 0;
    while (!in_ready) begin busy_cyc++; @(negedge clk); end
    model_byte(b, mode, bank);
    chk(busy_cyc == words_per_byte(mode), req, "R9 busy cycles",
        96'(busy_cyc), 96'(words_per_byte(mode)));
  endtask

  task automatic compare_ram(input string req);
    logic [95:0] a, e;
    for (int i = 0; i < NA; i++) begin
      a[i*4 +: 4] = dut_ram[i];
      e[i*4 +: 4] = exp_ram[i];
    end
    chk(a === e, req, "memory contents", a, e);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int w0;
    logic [7:0] b;
    string req;
    hw_subaddr = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready === 1'b1, "R1", "in_ready after reset", 96'(in_ready), 96'(1));
    chk(wr_en === 1'b0, "R1", "wr_en after reset", 96'(wr_en), 96'(0));
    chk(selected === 1'b1, "R1", "selected after reset", 96'(selected), 96'(1));
    seed(4'h3);
    mp = 0; ms = 0;
    send_byte(8'hC5, 3, 1'b0, -1, "R1");
    compare_ram("R1");

    // Sweep: mode x bank x start word x counter start (one below / equal)
    hw_subaddr = 3'd5;
    for (int m = 0; m < 4; m++) begin
      for (int bk = 0; bk < 2; bk++) begin
        for (int p = 0; p < NA; p++) begin
          for (int s = 4; s <= 5; s++) begin
            req = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
            seed(4'(p + s + m));
            load(p, s);
            chk(selected === (ms == 5), "R11", "selected after load",
                96'(selected), 96'(ms == 5));
            for (int k = 0; k < 3; k++) begin
              b = 8'((p * 29 + m * 53 + k * 101 + s) ^ 8'h96);
              send_byte(b, m, bk[0], -1, req);
            end
            compare_ram(bk ? "R6" : (s == 4 ? "R8" : req));
            chk(selected === (ms == 5), "R8", "selected after spill",
                96'(selected), 96'(ms == 5));
          end
        end
      end
    end

    // R7: counter never matches -> no writes at all, pointer still steps
    seed(4'h9);
    load(0, 7);
    w0 = wr_count;
    send_byte(8'hFF, 2, 1'b0, -1, "R7");
    send_byte(8'hA5, 2, 1'b0, -1, "R7");
    @(negedge clk);
    chk(wr_count == w0, "R7", "writes on mismatch", 96'(wr_count - w0), 96'(0));
    compare_ram("R7");

    // R10: mode and bank changed mid-byte are ignored
    seed(4'h1);
    load(2, 5);
    send_byte(8'h6B, 0, 1'b1, 3, "R10");
    send_byte(8'h3C, 1, 1'b1, 2, "R10");
    compare_ram("R10");

    // R9: second byte held valid through back-pressure
    seed(4'hE);
    load(20, 5);
    @(negedge clk);
    w0 = wr_count;
    in_byte = 8'h81; drive_mode = 2'd3; in_bank = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_byte = 8'h7E;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
    model_byte(8'h81, 3, 1'b0);
    model_byte(8'h7E, 3, 1'b0);
    chk(wr_count - w0 == 4, "R9", "writes for two held bytes",
        96'(wr_count - w0), 96'(4));
    compare_ram("R9");

    // R12: load value beyond last word is taken as 0
    seed(4'h5);
    load(30, 5);
    send_byte(8'hD2, 3, 1'b0, -1, "R12");
    compare_ram("R12");

    finish_run();
  end
endmodule